// File: doc/BRIEF.md
# Transmit Power Index Limiter

This block turns a regulatory ceiling on transmit power, given in whole dBm, into a ceiling on the power index of each of two modulation families: a narrowband family and a multicarrier family. It then limits the per-channel indices that the caller requests. Each family converts dBm to an index with its own straight-line rule and its own saturation point. A calibration select can replace both rules with a single generic one-index-per-dBm rule. After the regulatory limit, both indices are held to an absolute ceiling of 35. The final multicarrier index then picks a 2-bit amplifier bias class from two threshold bands.

The caller presents the ceiling, a flag saying whether the ceiling applies, the calibration select and the two requested indices, and pulses a load strobe for one cycle. The two final indices and the bias class are registered. They take their new values on the clock edge that samples the strobe and hold them until the next strobe.

Top module: `pwr_limit_top`

## Requirements
- R1: After a synchronous reset, both index outputs are 0 and the bias output is 2'b00.
- R2: The outputs change only on a clock edge at which `load` is 1, and then take the result of the inputs present at that edge. With `load` at 0 they hold their values whatever the other inputs do.
- R3: With `lin_cal`=1, the multicarrier ceiling is 2 × dBm, saturated to the range 0..40.
- R4: With `lin_cal`=1, the narrowband ceiling is 4 × dBm − 52, saturated to the range 0..28.
- R5: With `lin_cal`=0, both ceilings equal dBm, saturated to the range 0..35.
- R6: With `lim_valid`=1, a requested index larger than its family's ceiling is replaced by the ceiling. A request at or below the ceiling is kept.
- R7: With `lim_valid`=0, the ceiling has no effect, and each request passes on subject only to R8.
- R8: Each final index is at most 35. A larger value becomes 35.
- R9: The bias output is 2'b01 when the final multicarrier index is 17 or less, and 2'b10 when it is 18 or more.
- R10: The dBm input is two's complement over its full range. −128 gives ceilings of 0, and +127 saturates every ceiling, with no wraparound in the arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | One-cycle strobe that captures a new result |
| lim_valid | input | 1 | 1 = apply the regulatory ceiling |
| lin_cal | input | 1 | 1 = per-family rules, 0 = generic rule |
| lim_dbm | input | 8 | Regulatory ceiling in dBm, signed |
| req_nb | input | 8 | Requested narrowband index, unsigned |
| req_mc | input | 8 | Requested multicarrier index, unsigned |
| idx_nb | output | 8 | Final narrowband index |
| idx_mc | output | 8 | Final multicarrier index |
| bias | output | 2 | Multicarrier amplifier bias class |

## Verification
Two limiting functions can act on one index in the same cycle: the regulatory reduction and the absolute cap at 35. The bench provokes this in two ways. It runs the generic rule with a large dBm and requests above 35. It also runs the multicarrier rule with a ceiling of 40 against a request of 50, where only the cap can leave 35. In each case the result is compared with the smaller of the two bounds. The bench also aims a strobe at a value on the bias band edge, 17 against 18, reached through a ceiling reduction. Here the bias must follow the reduced index and not the request.

// File: rtl/pwr_limit_pkg.sv
package pwr_limit_pkg;

    typedef enum logic [1:0] {
        FAM_NB  = 2'd0,
        FAM_MC  = 2'd1,
        FAM_GEN = 2'd2
    } fam_e;

    typedef enum logic [1:0] {
        BIAS_NONE     = 2'b00,
        BIAS_MODERATE = 2'b01,
        BIAS_FULL     = 2'b10
    } bias_e;

    localparam int IDX_CAP     = 35;
    localparam int BIAS_THRESH = 17;

    // Index per dBm for each family, written as a left shift.
    function automatic int fam_shift(fam_e f);
        case (f)
            FAM_NB:  return 2;
            FAM_MC:  return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int fam_offset(fam_e f);
        case (f)
            FAM_NB:  return 52;
            default: return 0;
        endcase
    endfunction

    function automatic int fam_max(fam_e f);
        case (f)
            FAM_NB:  return 28;
            FAM_MC:  return 40;
            default: return 35;
        endcase
    endfunction

endpackage

// File: rtl/pwr_dbm_map.sv
module pwr_dbm_map
    import pwr_limit_pkg::*;
#(
    parameter int   DBM_W = 8,
    parameter int   IDX_W = 8,
    parameter fam_e FAM   = FAM_GEN
) (
    input  logic signed [DBM_W-1:0] dbm,
    output logic        [IDX_W-1:0] ceil_idx
);
    localparam int SH   = fam_shift(FAM);
    localparam int OFS  = fam_offset(FAM);
    localparam int MAXV = fam_max(FAM);
    localparam int LW   = DBM_W + 4;

    logic signed [LW-1:0] ext;
    logic signed [LW-1:0] lin;
    logic        [LW-1:0] lin_u;

    assign ext   = {{4{dbm[DBM_W-1]}}, dbm};
    assign lin   = (ext <<< SH) - $signed(LW'(OFS));
    assign lin_u = lin;

    always_comb begin
        if (lin[LW-1])
            ceil_idx = '0;
        else if (lin > $signed(LW'(MAXV)))
            ceil_idx = IDX_W'(MAXV);
        else
            ceil_idx = IDX_W'(lin_u);
    end
endmodule

// File: rtl/pwr_idx_clamp.sv
module pwr_idx_clamp
    import pwr_limit_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] req,
    input  logic [IDX_W-1:0] ceil_idx,
    input  logic             ceil_en,
    output logic [IDX_W-1:0] final_idx
);
    logic [IDX_W-1:0] reg_lim;

    always_comb begin
        reg_lim = req;
        if (ceil_en && (req > ceil_idx))
            reg_lim = ceil_idx;
        if (reg_lim > IDX_W'(IDX_CAP))
            final_idx = IDX_W'(IDX_CAP);
        else
            final_idx = reg_lim;
    end
endmodule

// File: rtl/pwr_bias_sel.sv
module pwr_bias_sel
    import pwr_limit_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] mc_idx,
    output bias_e            bias_cls
);
    always_comb begin
        if (mc_idx <= IDX_W'(BIAS_THRESH))
            bias_cls = BIAS_MODERATE;
        else
            bias_cls = BIAS_FULL;
    end
endmodule

// File: rtl/pwr_limit_top.sv
module pwr_limit_top
    import pwr_limit_pkg::*;
#(
    parameter int DBM_W = 8,
    parameter int IDX_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    lim_valid,
    input  logic                    lin_cal,
    input  logic signed [DBM_W-1:0] lim_dbm,
    input  logic        [IDX_W-1:0] req_nb,
    input  logic        [IDX_W-1:0] req_mc,
    output logic        [IDX_W-1:0] idx_nb,
    output logic        [IDX_W-1:0] idx_mc,
    output logic        [1:0]       bias
);
    typedef struct packed {
        logic [IDX_W-1:0] nb;
        logic [IDX_W-1:0] mc;
        bias_e            bias;
    } result_t;

    localparam int NFAM = 3;

    logic [IDX_W-1:0] ceil_w [NFAM];
    logic [IDX_W-1:0] ceil_nb, ceil_mc;
    result_t          nxt, cur;

    genvar g;
    generate
        for (g = 0; g < NFAM; g++) begin : g_map
            pwr_dbm_map #(
                .DBM_W(DBM_W),
                .IDX_W(IDX_W),
                .FAM  (fam_e'(g))
            ) u_map (
                .dbm     (lim_dbm),
                .ceil_idx(ceil_w[g])
            );
        end
    endgenerate

    assign ceil_nb = lin_cal ? ceil_w[FAM_NB] : ceil_w[FAM_GEN];
    assign ceil_mc = lin_cal ? ceil_w[FAM_MC] : ceil_w[FAM_GEN];

    pwr_idx_clamp #(.IDX_W(IDX_W)) u_clamp_nb (
        .req      (req_nb),
        .ceil_idx (ceil_nb),
        .ceil_en  (lim_valid),
        .final_idx(nxt.nb)
    );

    pwr_idx_clamp #(.IDX_W(IDX_W)) u_clamp_mc (
        .req      (req_mc),
        .ceil_idx (ceil_mc),
        .ceil_en  (lim_valid),
        .final_idx(nxt.mc)
    );

    pwr_bias_sel #(.IDX_W(IDX_W)) u_bias (
        .mc_idx  (nxt.mc),
        .bias_cls(nxt.bias)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '{nb: '0, mc: '0, bias: BIAS_NONE};
        else if (load)
            cur <= nxt;
    end

    assign idx_nb = cur.nb;
    assign idx_mc = cur.mc;
    assign bias   = cur.bias;
endmodule

// File: rtl/pwr_limit_chk.sv
module pwr_limit_chk
    import pwr_limit_pkg::*;
#(
    parameter int DBM_W = 8,
    parameter int IDX_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    load,
    input logic                    lim_valid,
    input logic                    lin_cal,
    input logic signed [DBM_W-1:0] lim_dbm,
    input logic        [IDX_W-1:0] req_nb,
    input logic        [IDX_W-1:0] req_mc,
    input logic        [IDX_W-1:0] idx_nb,
    input logic        [IDX_W-1:0] idx_mc,
    input logic        [1:0]       bias
);
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(idx_nb) && $stable(idx_mc) && $stable(bias))); // R2

    AST_IDX_CAP: assert property (@(posedge clk) disable iff (rst)
        load |=> (idx_nb <= IDX_W'(IDX_CAP) && idx_mc <= IDX_W'(IDX_CAP))); // R8

    AST_BIAS_BAND: assert property (@(posedge clk) disable iff (rst)
        load |=> ((idx_mc <= IDX_W'(BIAS_THRESH)) ? (bias == 2'b01) : (bias == 2'b10))); // R9

    AST_NO_LIMIT_PASS: assert property (@(posedge clk) disable iff (rst)
        (load && !lim_valid) |=>
            (idx_nb == (($past(req_nb) > IDX_W'(IDX_CAP)) ? IDX_W'(IDX_CAP) : $past(req_nb)))); // R7

    AST_NEVER_RAISE: assert property (@(posedge clk) disable iff (rst)
        (load && lim_valid) |=> (idx_mc <= $past(req_mc) && idx_nb <= $past(req_nb))); // R6
endmodule

bind pwr_limit_top pwr_limit_chk #(.DBM_W(DBM_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_pwr_limit_top.sv
module sim_pwr_limit_top;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load = 1'b0;
    logic              lim_valid = 1'b0;
    logic              lin_cal = 1'b1;
    logic signed [7:0] lim_dbm = '0;
    logic        [7:0] req_nb = '0;
    logic        [7:0] req_mc = '0;
    logic        [7:0] idx_nb, idx_mc;
    logic        [1:0] bias;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    pwr_limit_top u0 (
        .clk(clk), .rst(rst), .load(load), .lim_valid(lim_valid),
        .lin_cal(lin_cal), .lim_dbm(lim_dbm), .req_nb(req_nb),
        .req_mc(req_mc), .idx_nb(idx_nb), .idx_mc(idx_mc), .bias(bias)
    );

    function automatic int sat(int v, int hi);
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    // fam: 0 narrowband, 1 multicarrier, 2 generic
    function automatic int ceil_of(int fam, int dbm);
        case (fam)
            0:       return sat(4 * dbm - 52, 28);
            1:       return sat(2 * dbm, 40);
            default: return sat(dbm, 35);
        endcase
    endfunction

    function automatic int final_of(int req, int ceil_v, bit lv);
        int r = req;
        if (lv && r > ceil_v) r = ceil_v;
        if (r > 35) r = 35;
        return r;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(bit lv, bit cal, int dbm, int rn, int rm);
        @(negedge clk);
        lim_valid = lv; lin_cal = cal;
        lim_dbm = 8'(dbm); req_nb = 8'(rn); req_mc = 8'(rm);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic apply_check(string tag, bit lv, bit cal, int dbm, int rn, int rm);
        int en, em;
        apply(lv, cal, dbm, rn, rm);
        en = final_of(rn, ceil_of(cal ? 0 : 2, dbm), lv);
        em = final_of(rm, ceil_of(cal ? 1 : 2, dbm), lv);
        check({tag, " nb"}, idx_nb, en);
        check({tag, " mc"}, idx_mc, em);
        check({tag, " bias"}, bias, (em <= 17) ? 1 : 2);
    endtask

    task automatic t_reset;
        check("R1 reset nb", idx_nb, 0);
        check("R1 reset mc", idx_mc, 0);
        check("R1 reset bias", bias, 0);
    endtask

    task automatic t_mc_rule;
        apply_check("R3 mc dbm=5", 1, 1, 5, 60, 60);
        apply_check("R3 mc dbm=-3", 1, 1, -3, 60, 60);
        apply_check("R3 mc dbm=30 sat40", 1, 1, 30, 60, 38);
        check("R3 mc direct", idx_mc, 35);
    endtask

    task automatic t_nb_rule;
        apply_check("R4 nb dbm=15", 1, 1, 15, 30, 10);
        check("R4 nb direct", idx_nb, 8);
        apply_check("R4 nb dbm=13 zero", 1, 1, 13, 30, 10);
        apply_check("R4 nb dbm=12 neg", 1, 1, 12, 30, 10);
        apply_check("R4 nb dbm=20 sat28", 1, 1, 20, 30, 10);
        check("R4 nb sat direct", idx_nb, 28);
    endtask

    task automatic t_generic;
        apply_check("R5 gen dbm=20", 1, 0, 20, 30, 30);
        check("R5 gen direct", idx_nb, 20);
        apply_check("R5 gen dbm=50 sat", 1, 0, 50, 40, 40);
    endtask

    task automatic t_reduce_keep;
        apply_check("R6 keep below", 1, 1, 10, 3, 12);
        check("R6 keep direct", idx_mc, 12);
        apply_check("R6 reduce", 1, 1, 4, 20, 20);
        check("R6 reduce direct", idx_mc, 8);
    endtask

    task automatic t_no_limit;
        apply_check("R7 invalid ignores -100", 0, 1, -100, 22, 30);
        check("R7 direct mc", idx_mc, 30);
        check("R7 direct nb", idx_nb, 22);
    endtask

    task automatic t_cap;
        apply_check("R8 cap req 200", 0, 1, 0, 200, 36);
        check("R8 cap direct", idx_nb, 35);
        apply_check("R8 coincide 40 vs 50", 1, 1, 25, 50, 50);
    endtask

    task automatic t_bias_edges;
        apply_check("R9 bias 17", 0, 1, 0, 0, 17);
        check("R9 bias 17 direct", bias, 1);
        apply_check("R9 bias 18", 0, 1, 0, 0, 18);
        check("R9 bias 18 direct", bias, 2);
        apply_check("R9 reduced to 18 then cal gen 17", 1, 0, 17, 0, 30);
        check("R9 reduced direct", bias, 1);
    endtask

    task automatic t_extremes;
        apply_check("R10 dbm=-128", 1, 1, -128, 50, 50);
        check("R10 -128 direct", idx_mc, 0);
        apply_check("R10 dbm=127", 1, 1, 127, 50, 50);
        check("R10 127 direct nb", idx_nb, 28);
        apply_check("R10 gen 127", 1, 0, 127, 50, 50);
    endtask

    task automatic t_hold;
        int hn, hm, hb;
        apply_check("R2 setup", 1, 1, 6, 9, 9);
        hn = idx_nb; hm = idx_mc; hb = bias;
        @(negedge clk);
        lim_valid = 1'b0; lin_cal = 1'b0; lim_dbm = 8'sd100;
        req_nb = 8'd33; req_mc = 8'd2;
        repeat (3) @(negedge clk);
        check("R2 hold nb", idx_nb, hn);
        check("R2 hold mc", idx_mc, hm);
        check("R2 hold bias", bias, hb);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check("R2 load nb", idx_nb, 33);
        check("R2 load mc", idx_mc, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        @(negedge clk);
        rst = 1'b0;
        t_mc_rule;
        t_nb_rule;
        t_generic;
        t_reduce_keep;
        t_no_limit;
        t_cap;
        t_bias_edges;
        t_extremes;
        t_hold;
        @(negedge clk);
        rst = 1'b1; load = 1'b1;
        @(negedge clk);
        rst = 1'b0; load = 1'b0;
        t_reset;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule